// File: doc/BRIEF.md
# Dual-Read Register File with Per-Port Read Timing

This block is a small storage primitive for a tile of a reconfigurable fabric. It holds 32 words of 4 bits. It has one write port and two read ports, A and B. Each read port has its own address and its own data output, so two different words can be read in the same cycle. All three ports run on one shared clock.

A static 2-bit mode input sets the read timing of each port on its own. A port in combinational mode shows the word at its current address in the same cycle. A port in registered mode shows, after a rising edge, the word that was stored at the address it had at that edge. When a registered read meets a write to the same address on the same edge, the read returns the word as it was before that write. The array contents are never reset. The asynchronous active-low reset clears only the two read output registers.

Top module: `dual_read_regfile`

## Requirements
- R1: On a rising edge with `wr_en_i` high, `wr_data_i` is stored at `wr_addr_i`. With `wr_en_i` low, no stored word changes.
- R2: With `mode_i[0]` = 0, `rd_a_data_o` equals the word stored at `rd_a_addr_i` in the same cycle, with no clock edge in between.
- R3: With `mode_i[1]` = 0, `rd_b_data_o` equals the word stored at `rd_b_addr_i` in the same cycle.
- R4: With `mode_i[0]` = 1, after each rising edge `rd_a_data_o` equals the word that was stored at the `rd_a_addr_i` sampled at that edge. The output register loads on every edge and has no read enable.
- R5: With `mode_i[1]` = 1, after each rising edge `rd_b_data_o` equals the word that was stored at the `rd_b_addr_i` sampled at that edge.
- R6: A registered read and a write to the same address on the same edge give the word from before the write.
- R7: A combinational read of an address that was written on the previous edge shows the new word immediately after that edge.
- R8: While `rst_ni` is low, and until the first edge after it goes high, a port in registered mode outputs 0.
- R9: Ports A and B work independently. They read different addresses in the same cycle, and all four mode settings (00, 01, 10, 11) behave as R2 to R5 describe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared clock for all ports |
| rst_ni | input | 1 | Asynchronous active-low reset of the read output registers |
| mode_i | input | 2 | Read timing per port: bit 0 for port A, bit 1 for port B; 1 = registered, 0 = combinational |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 4 | Write data |
| rd_a_addr_i | input | 5 | Port A read address |
| rd_a_data_o | output | 4 | Port A read data |
| rd_b_addr_i | input | 5 | Port B read address |
| rd_b_data_o | output | 4 | Port B read data |

## Verification
A combinational read result is due in the same cycle as its address, so the bench drives inputs on the falling edge and samples 1 ns later, before the rising edge. A registered result and a combinational read of a freshly written word are both due one rising edge later, so the bench samples them on the next falling edge. The expected registered value is taken from the reference model before that model applies the write, which gives the old-data answer on collisions. The bound checker covers the same timing: it compares a registered port A against port B's combinational value from the cycle before, and it checks a combinational read against the write from the previous edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_DATA_W = 4;
  localparam int unsigned RF_ADDR_W = 5;
  localparam int unsigned RF_NUM_RD = 2;

  typedef enum logic {
    RD_COMB = 1'b0,
    RD_REG  = 1'b1
  } rd_timing_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DATA_W = rf_pkg::RF_DATA_W,
  parameter int unsigned ADDR_W = rf_pkg::RF_ADDR_W,
  parameter int unsigned NUM_RD = rf_pkg::RF_NUM_RD
) (
  input  logic                           clk_i,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_word_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  row_en;

  // one-hot row decode of the write port
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    assign row_en[r] = wr_en_i && (wr_addr_i == ADDR_W'(r));
  end

  // storage is intentionally not reset
  always_ff @(posedge clk_i) begin
    for (int r = 0; r < DEPTH; r++) begin
      if (row_en[r]) mem_q[r] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_word_o[p] = mem_q[rd_addr_i[p]];
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W = rf_pkg::RF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rf_pkg::rd_timing_e timing_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o
);
  logic              ld_en;
  logic [DATA_W-1:0] hold_d;
  logic [DATA_W-1:0] hold_q;

  // the output register captures on every edge
  assign ld_en = 1'b1;

  always_comb begin
    hold_d = hold_q;
    if (ld_en) hold_d = word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign data_o = (timing_i == rf_pkg::RD_REG) ? hold_q : word_i;
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
  parameter int unsigned DATA_W = rf_pkg::RF_DATA_W,
  parameter int unsigned ADDR_W = rf_pkg::RF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [ADDR_W-1:0] rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o
);
  localparam int unsigned NUM_RD = 2;

  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_word;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

  assign rd_addr[0] = rd_a_addr_i;
  assign rd_addr[1] = rd_b_addr_i;

  rf_storage #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_RD (NUM_RD)
  ) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_word_o (rd_word)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    rf_read_port #(
      .DATA_W (DATA_W)
    ) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .timing_i (rf_pkg::rd_timing_e'(mode_i[p])),
      .word_i   (rd_word[p]),
      .data_o   (rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
endmodule

// File: rtl/dual_read_regfile_chk.sv
module dual_read_regfile_chk #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [ADDR_W-1:0] rd_a_addr_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [ADDR_W-1:0] rd_b_addr_i,
  input logic [DATA_W-1:0] rd_b_data_o
);
  logic past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_COMB_PORTS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && rd_a_addr_i == rd_b_addr_i) |-> rd_a_data_o == rd_b_data_o); // R9

  AST_REG_PORTS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && mode_i == 2'b11 && $past(rd_a_addr_i) == $past(rd_b_addr_i))
    |-> rd_a_data_o == rd_b_data_o); // R5

  AST_REG_A_OLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && mode_i == 2'b01 && $past(mode_i) == 2'b01 &&
     $past(rd_a_addr_i) == $past(rd_b_addr_i))
    |-> rd_a_data_o == $past(rd_b_data_o)); // R6

  AST_COMB_SEES_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !mode_i[0] && $past(wr_en_i) && $past(wr_addr_i) == rd_a_addr_i)
    |-> rd_a_data_o == $past(wr_data_i)); // R7

  always @(negedge clk_i) begin
    if (!rst_ni && mode_i[1]) begin
      AST_RESET_REG_ZERO: assert (rd_b_data_o == '0); // R8
    end
  end
endmodule

bind dual_read_regfile dual_read_regfile_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .rd_a_addr_i (rd_a_addr_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_addr_i (rd_b_addr_i),
  .rd_b_data_o (rd_b_data_o)
);

// File: tb/dual_read_regfile_tb_top.sv
`timescale 1ns/1ps
module dual_read_regfile_tb_top;
  localparam int DW = 4;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC = 16;

  // vector fields: mode[21:20] we[19] waddr[18:14] wdata[13:10] aaddr[9:5] baddr[4:0]
  localparam logic [21:0] VEC [NVEC] = '{
    {2'b00, 1'b1, 5'd3,  4'hA, 5'd3,  5'd4},
    {2'b00, 1'b0, 5'd9,  4'h1, 5'd9,  5'd3},
    {2'b01, 1'b1, 5'd7,  4'h5, 5'd7,  5'd7},
    {2'b01, 1'b0, 5'd0,  4'h0, 5'd7,  5'd31},
    {2'b10, 1'b1, 5'd12, 4'hC, 5'd1,  5'd12},
    {2'b10, 1'b1, 5'd1,  4'h6, 5'd1,  5'd12},
    {2'b11, 1'b1, 5'd20, 4'hF, 5'd20, 5'd20},
    {2'b11, 1'b0, 5'd20, 4'h2, 5'd20, 5'd12},
    {2'b11, 1'b1, 5'd31, 4'h9, 5'd0,  5'd31},
    {2'b00, 1'b1, 5'd31, 4'h4, 5'd31, 5'd0},
    {2'b01, 1'b1, 5'd0,  4'h8, 5'd0,  5'd0},
    {2'b10, 1'b1, 5'd15, 4'h3, 5'd16, 5'd15},
    {2'b11, 1'b1, 5'd16, 4'hE, 5'd15, 5'd16},
    {2'b00, 1'b0, 5'd16, 4'h1, 5'd16, 5'd15},
    {2'b01, 1'b1, 5'd5,  4'h7, 5'd6,  5'd5},
    {2'b10, 1'b1, 5'd6,  4'hB, 5'd6,  5'd5}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [1:0]    mode_i;
  logic          wr_en_i;
  logic [AW-1:0] wr_addr_i;
  logic [DW-1:0] wr_data_i;
  logic [AW-1:0] rd_a_addr_i;
  logic [DW-1:0] rd_a_data_o;
  logic [AW-1:0] rd_b_addr_i;
  logic [DW-1:0] rd_b_data_o;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  dual_read_regfile dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_a_addr_i (rd_a_addr_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_addr_i (rd_b_addr_i),
    .rd_b_data_o (rd_b_data_o)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [1:0] m, input logic we, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input logic [AW-1:0] aa, input logic [AW-1:0] ba);
    logic [DW-1:0] exp_a, exp_b;
    mode_i = m; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    rd_a_addr_i = aa; rd_b_addr_i = ba;
    #1;
    if (!m[0]) chk("R2 comb A same cycle", rd_a_data_o, ref_mem[aa]);
    if (!m[1]) chk("R3 comb B same cycle", rd_b_data_o, ref_mem[ba]);
    exp_a = ref_mem[aa];
    exp_b = ref_mem[ba];
    @(posedge clk_i);
    if (we) ref_mem[wa] = wd;
    @(negedge clk_i);
    if (m[0]) begin
      if (we && wa == aa) chk("R6 reg A collision", rd_a_data_o, exp_a);
      else                chk("R4 reg A", rd_a_data_o, exp_a);
    end else chk("R7 comb A after edge", rd_a_data_o, ref_mem[aa]);
    if (m[1]) begin
      if (we && wa == ba) chk("R6 reg B collision", rd_b_data_o, exp_b);
      else                chk("R5 reg B", rd_b_data_o, exp_b);
    end else chk("R7 comb B after edge", rd_b_data_o, ref_mem[ba]);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_ni = 1'b0; mode_i = 2'b11; wr_en_i = 1'b0;
    wr_addr_i = '0; wr_data_i = '0; rd_a_addr_i = '0; rd_b_addr_i = '0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 reset A", rd_a_data_o, '0);
    chk("R8 reset B", rd_b_data_o, '0);
    rst_ni = 1'b1;
    #1;
    chk("R8 after release A", rd_a_data_o, '0);
    chk("R8 after release B", rd_b_data_o, '0);
    @(negedge clk_i);

    // fill every word so the model is fully known
    for (int i = 0; i < DEPTH; i++) begin
      mode_i = 2'b00; wr_en_i = 1'b1;
      wr_addr_i = AW'(i); wr_data_i = DW'(i * 7 + 3);
      @(posedge clk_i);
      ref_mem[i] = DW'(i * 7 + 3);
      @(negedge clk_i);
    end

    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][21:20], VEC[v][19], VEC[v][18:14], VEC[v][13:10], VEC[v][9:5], VEC[v][4:0]);
    end

    // R1: disabled write leaves the word unchanged
    step(2'b00, 1'b0, 5'd10, ~ref_mem[10], 5'd10, 5'd11);
    chk("R1 no write when disabled", rd_a_data_o, DW'(10 * 7 + 3));
    // R1: enabled write then read back
    step(2'b00, 1'b1, 5'd10, 4'h0, 5'd11, 5'd10);
    chk("R1 write stored", rd_b_data_o, 4'h0);

    // R9: independent addresses and mixed timing
    step(2'b01, 1'b0, 5'd0, 4'h0, 5'd2, 5'd25);
    chk("R9 port A word 2", rd_a_data_o, DW'(2 * 7 + 3));
    chk("R9 port B word 25", rd_b_data_o, DW'(25 * 7 + 3));

    // R6 then R4: collision old word, next edge shows new word
    step(2'b11, 1'b1, 5'd8, 4'hD, 5'd8, 5'd8);
    step(2'b11, 1'b0, 5'd8, 4'h0, 5'd8, 5'd8);
    chk("R4 reg A new word next edge", rd_a_data_o, 4'hD);
    chk("R5 reg B new word next edge", rd_b_data_o, 4'hD);

    report();
  end
endmodule